// File: doc/BRIEF.md
# Preloadable Up-Counter Timer with Selectable Event Source

The block is a free-standing up-counting timer. Software writes a start value, picks what advances the count and sets the run bit. From then on the timer needs no further attention. On each count event the counter goes up by one. When an event arrives while the counter holds its all-ones value, the counter overflows. It then loads the start value again and raises a sticky overflow flag. A control bit chooses what happens next: the timer keeps going, or it clears its own run bit and halts.

The count can advance on every clock cycle or on every 32nd clock cycle. It can also follow rising edges on an asynchronous event input, which first passes through a synchroniser. A small four-word register port sets up the timer and reads it back. The interrupt output is the overflow flag gated by an enable bit.

Top module: `reload_timer`

## Requirements
- R1: While running, each count event raises the counter (read at address 3) by exactly one, starting from the value loaded from the preload register (address 0).
- R2: An event that arrives while the counter is all ones is an overflow, and it sets the sticky flag in bit 0 of the status word (address 2).
- R3: With the auto bit (control address 1, bit 1) set, an overflow loads the preload value on the same edge and the timer keeps running.
- R4: With the auto bit clear, an overflow loads the preload value and clears the run bit (control bit 0), so the count then holds.
- R5: Control bits 3:2 select the event source. 0 is every clock. 1 is every 32nd clock, with the first event 32 cycles after the run bit is set. 2 is one event per rising edge of `ext_evt`, after a two-flop synchroniser; a held-high level counts once. 3 is no events.
- R6: A write to the preload register while the timer is stopped also loads the counter at once. While the timer runs, the write changes only the preload register.
- R7: `irq` is high exactly when the overflow flag is set and the interrupt-enable bit (control bit 4) is set.
- R8: Writing 1 to status bit 0 clears the flag. Writing 0 leaves it unchanged.
- R9: If a clear write and an overflow happen on the same edge, the flag ends up set.
- R10: After reset every register reads zero and `irq` is low. Writes to the count address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 preload, 1 control, 2 status, 3 count |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| ext_evt | input | 1 | Asynchronous external event input |
| irq | output | 1 | Interrupt: overflow flag AND enable |

## Verification
A write takes effect on the edge that samples it, so reads that follow track the counter one cycle per edge. With the clock source, a run-bit write makes the counter show the start value at the next falling edge and one more at each falling edge after that. An overflow is visible in the count and in the flag at the falling edge after the overflowing rising edge. The divided source first advances 32 edges after start. A pin edge reaches the count three edges after the pin is driven. The driver queues each expected value for a chosen falling edge, and the monitor compares it 2 ns after that edge, so every sample falls inside the cycle counted for it.

// File: rtl/rt_pkg.sv
package rt_pkg;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_PRELOAD = 2'd0;
  localparam logic [ADDR_W-1:0] A_CTRL    = 2'd1;
  localparam logic [ADDR_W-1:0] A_STATUS  = 2'd2;
  localparam logic [ADDR_W-1:0] A_COUNT   = 2'd3;

  localparam int unsigned B_RUN  = 0;
  localparam int unsigned B_AUTO = 1;
  localparam int unsigned B_SRC  = 2;
  localparam int unsigned B_IEN  = 4;

  typedef enum logic [1:0] {
    SRC_CLK  = 2'd0,
    SRC_DIV  = 2'd1,
    SRC_PIN  = 2'd2,
    SRC_NONE = 2'd3
  } src_e;

  function automatic logic [15:0] rt_incr(input logic [15:0] v);
    return v + 16'd1;
  endfunction

  function automatic logic rt_at_top(input logic [15:0] v);
    return &v;
  endfunction
endpackage

// File: rtl/rt_prescaler.sv
module rt_prescaler #(
  parameter int unsigned DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam int unsigned PS_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PS_W-1:0] LAST = PS_W'(DIV - 1);

  logic [PS_W-1:0] psc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          psc_q <= '0;
    else if (restart)    psc_q <= '0;
    else if (psc_q == LAST) psc_q <= '0;
    else                 psc_q <= psc_q + 1'b1;
  end

  assign tick = run && (psc_q == LAST);
endmodule

// File: rtl/rt_edge_sync.sv
module rt_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q[0] <= 1'b0;
    else        sh_q[0] <= din;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q[i] <= 1'b0;
      else        sh_q[i] <= sh_q[i-1];
    end
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/rt_counter.sv
module rt_counter
  import rt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        load_en,
  input  logic [15:0] load_val,
  output logic [15:0] count,
  output logic        ovf
);
  logic [15:0] cnt_q;

  assign ovf = tick && rt_at_top(cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (load_en) cnt_q <= load_val;
    else if (tick)    cnt_q <= rt_incr(cnt_q);
  end

  assign count = cnt_q;
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import rt_pkg::*;
#(
  parameter int unsigned PRESCALE    = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic        ext_evt,
  output logic        irq
);
  logic [15:0] preload_q;
  logic        run_q, auto_q, ien_q, flag_q;
  src_e        src_q;

  logic pre_wr, ctrl_wr, clr_wr, start;
  logic div_tick, pin_rise, tick, ovf;
  logic load_en;
  logic [15:0] load_val, count_q;

  assign pre_wr  = wr_en && (addr == A_PRELOAD);
  assign ctrl_wr = wr_en && (addr == A_CTRL);
  assign clr_wr  = wr_en && (addr == A_STATUS) && wdata[0];
  assign start   = ctrl_wr && wdata[B_RUN] && !run_q;

  rt_prescaler #(.DIV(PRESCALE)) u_psc (
    .clk(clk), .rst_n(rst_n), .restart(start), .run(run_q), .tick(div_tick)
  );

  rt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(ext_evt), .rise(pin_rise)
  );

  always_comb begin
    unique case (src_q)
      SRC_CLK:  tick = run_q;
      SRC_DIV:  tick = div_tick;
      SRC_PIN:  tick = run_q && pin_rise;
      default:  tick = 1'b0;
    endcase
  end

  assign load_en  = ovf || (pre_wr && !run_q);
  assign load_val = ovf ? preload_q : wdata;

  rt_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load_en(load_en),
    .load_val(load_val), .count(count_q), .ovf(ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preload_q <= '0;
      run_q     <= 1'b0;
      auto_q    <= 1'b0;
      ien_q     <= 1'b0;
      src_q     <= SRC_CLK;
      flag_q    <= 1'b0;
    end else begin
      if (pre_wr) preload_q <= wdata;
      if (ctrl_wr) begin
        auto_q <= wdata[B_AUTO];
        ien_q  <= wdata[B_IEN];
        src_q  <= src_e'(wdata[B_SRC +: 2]);
      end
      if (ovf && !auto_q)  run_q <= 1'b0;
      else if (ctrl_wr)    run_q <= wdata[B_RUN];
      if (ovf)             flag_q <= 1'b1;
      else if (clr_wr)     flag_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_PRELOAD: rdata = preload_q;
      A_CTRL: begin
        rdata[B_RUN]      = run_q;
        rdata[B_AUTO]     = auto_q;
        rdata[B_SRC +: 2] = src_q;
        rdata[B_IEN]      = ien_q;
      end
      A_STATUS:  rdata[0] = flag_q;
      default:   rdata = count_q;
    endcase
  end

  assign irq = flag_q && ien_q;
endmodule

// File: rtl/rt_checker.sv
module rt_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        ovf,
  input logic [15:0] count_q,
  input logic [15:0] preload_q,
  input logic        run_q,
  input logic        auto_q,
  input logic        ien_q,
  input logic        flag_q,
  input logic        pre_wr,
  input logic        ctrl_wr,
  input logic        clr_wr,
  input logic        irq
);
  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ovf) |=> count_q == $past(count_q) + 16'd1);

  a_r2_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> flag_q);

  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> count_q == $past(preload_q));

  a_r3_keep_running: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && auto_q && !ctrl_wr) |=> run_q);

  a_r4_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !auto_q) |=> !run_q);

  a_r6_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !pre_wr) |=> $stable(count_q));

  a_r7_mask: assert property (@(posedge clk) disable iff (!rst_n)
    !ien_q |-> !irq);

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !ovf) |=> !flag_q);
endmodule

bind reload_timer rt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .ovf(ovf), .count_q(count_q),
  .preload_q(preload_q), .run_q(run_q), .auto_q(auto_q), .ien_q(ien_q),
  .flag_q(flag_q), .pre_wr(pre_wr), .ctrl_wr(ctrl_wr), .clr_wr(clr_wr),
  .irq(irq)
);

// File: tb/reload_timer_bench.sv
`timescale 1ns/1ps
module reload_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        ext_evt = 1'b0;
  logic        irq;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  reload_timer u_reload_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ext_evt(ext_evt), .irq(irq)
  );

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic expect_reg(input logic [1:0] a, input logic [15:0] e, input string tag);
    item_t it;
    @(negedge clk);
    addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic expect_irq(input logic e, input string tag);
    item_t it;
    @(negedge clk);
    it.is_irq = 1'b1; it.exp = {15'd0, e}; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_evt = 1'b1;
      repeat (4) @(negedge clk);
      ext_evt = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  // monitor: compares each queued expectation 2 ns after its falling edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = sb_q.pop_front();
        act = it.is_irq ? {15'd0, irq} : rdata;
        n_checks++;
        if (act !== it.exp) begin
          n_fails++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    expect_reg(2'd0, 16'h0000, "R10 preload after reset");
    expect_reg(2'd1, 16'h0000, "R10 control after reset");
    expect_reg(2'd2, 16'h0000, "R10 status after reset");
    expect_reg(2'd3, 16'h0000, "R10 count after reset");
    expect_irq(1'b0, "R10 irq after reset");

    // R6 preload while stopped, R1 counting on clock source
    wr(2'd0, 16'h1234);
    wr(2'd1, 16'h0003);
    expect_reg(2'd3, 16'h1234, "R6 counter loaded while stopped");
    expect_reg(2'd3, 16'h1235, "R1 first increment");
    expect_reg(2'd3, 16'h1236, "R1 second increment");
    wr(2'd1, 16'h0000);

    // R3 auto reload, R2 flag, R7 irq
    wr(2'd0, 16'hFFFE);
    wr(2'd1, 16'h0013);
    expect_reg(2'd3, 16'hFFFE, "R1 start value");
    expect_reg(2'd3, 16'hFFFF, "R1 at top");
    expect_reg(2'd3, 16'hFFFE, "R3 reloaded after overflow");
    expect_reg(2'd2, 16'h0001, "R2 flag set");
    expect_irq(1'b1, "R7 irq with enable");
    wr(2'd1, 16'h0010);
    expect_irq(1'b1, "R7 irq stays while flag set");
    wr(2'd1, 16'h0000);
    expect_irq(1'b0, "R7 irq masked");

    // R8 clearing
    wr(2'd2, 16'h0000);
    expect_reg(2'd2, 16'h0001, "R8 writing 0 keeps flag");
    wr(2'd2, 16'h0001);
    expect_reg(2'd2, 16'h0000, "R8 writing 1 clears flag");

    // R4 one-shot
    wr(2'd0, 16'hFFFD);
    wr(2'd1, 16'h0001);
    idle(8);
    expect_reg(2'd1, 16'h0000, "R4 run bit cleared");
    expect_reg(2'd3, 16'hFFFD, "R4 count reloaded and held");
    expect_reg(2'd2, 16'h0001, "R2 flag after one-shot");

    // R9 overflow beats clear on the same edge
    wr(2'd0, 16'hFFFF);
    wr(2'd1, 16'h0001);
    wr(2'd2, 16'h0001);
    expect_reg(2'd2, 16'h0001, "R9 overflow wins over clear");
    wr(2'd2, 16'h0001);
    expect_reg(2'd2, 16'h0000, "R8 clear after collision");

    // R5 divide-by-32 source
    wr(2'd0, 16'h0010);
    wr(2'd1, 16'h0007);
    idle(31);
    expect_reg(2'd3, 16'h0010, "R5 no divided event before 32 cycles");
    expect_reg(2'd3, 16'h0011, "R5 divided event at 32 cycles");
    wr(2'd1, 16'h0000);

    // R5 external pin source
    wr(2'd0, 16'h0100);
    wr(2'd1, 16'h000B);
    pulse(1);
    expect_reg(2'd3, 16'h0101, "R5 one pin edge counted once");
    pulse(3);
    expect_reg(2'd3, 16'h0104, "R5 three more pin edges");
    wr(2'd1, 16'h0000);

    // R5 source code 3 gives no events
    wr(2'd0, 16'h0200);
    wr(2'd1, 16'h000F);
    idle(40);
    pulse(1);
    expect_reg(2'd3, 16'h0200, "R5 no events for source 3");
    wr(2'd1, 16'h0000);

    // R10 count is read-only
    wr(2'd3, 16'hAAAA);
    expect_reg(2'd3, 16'h0200, "R10 count write ignored");

    // R6 preload write while running leaves the count alone
    wr(2'd1, 16'h0003);
    wr(2'd0, 16'h7777);
    expect_reg(2'd3, 16'h0201, "R6 running count not loaded");
    expect_reg(2'd0, 16'h7777, "R6 preload register updated");
    wr(2'd1, 16'h0000);

    idle(3);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule